// File: doc/BRIEF.md
# Multi-Channel Timer PWM Unit

This block holds a bank of independent 16-bit timer channels. Each channel can drive one pulse-width-modulated pin. A channel counts up on the cycles where its own prescaled clock-enable input is high. When a period starts, its pin rests at a programmable starting level. The pin takes the opposite level once the count reaches the duty compare value. At the period compare value the count wraps to zero, the pin returns to the starting level, and a sticky end-of-period flag is raised.

Software programs the bank through a plain register bus with separate read and write strobes, an address and a data word. Reads return data one cycle after the read strobe. Each channel owns four consecutive words: the counter at offset 0, duty at 1, period at 2 and control at 3. The shared words follow the last channel. They are a start mask, a stop mask, a running-status word and a flag word.

A write-one bit in the start mask or the stop mask starts or stops the matching channel. Zero bits leave their channels alone. Each channel selects how a stop behaves. An abrupt stop drops the pin to its starting level at once. A graceful stop lets the current period finish first. Channels 0 and 1 are normally left to system timekeeping, but the hardware treats every channel the same way.

Top module: `tpwm_bank`

## Requirements
- R1: After a synchronous active-high reset, every counter, duty, period and control register reads 0, no channel runs, and every pin and end-of-period flag is low.
- R2: Channel n's registers sit at word 4n+k, with k = 0 for the counter, 1 for duty, 2 for period and 3 for control. The control bits are bit0 = output enable, bit1 = starting level high and bit2 = abrupt stop; reading control returns only these three bits. The shared words sit at 4N+0 (start mask), 4N+1 (stop mask), 4N+2 (running status, read) and 4N+3 (flags). A read returns data on bus_rdata one cycle after bus_rd.
- R3: A counter advances by one only on a clock cycle where its channel is running and its tick input is high; otherwise it holds its value.
- R4: With output enable set and the channel running, the pin is at the starting level while the count is below duty, and at the opposite level from duty through period. The count then wraps to 0 on the next tick, so each period spans period+1 ticks with period-duty+1 of them at the opposite level.
- R5: When duty is greater than period, the pin stays at the starting level for the whole period.
- R6: Writing 1 to bit n of the start mask starts channel n, and writing 1 to bit n of the stop mask stops it; bits written as 0 change nothing.
- R7: Software can write a channel's counter at any time, and that write overrides a tick in the same cycle. Writing 0 restarts the period from the start.
- R8: While output enable is clear or the channel is stopped, the pin follows the starting level, one cycle after the state that causes it.
- R9: With abrupt stop selected, a stop request halts the counter at once and the pin shows the starting level from the second cycle after the write.
- R10: With graceful stop selected, a stop request leaves the channel running until the current period ends. The channel then halts with its counter at 0, and running status keeps showing the channel until then.
- R11: A channel's flag bit is set when its running counter wraps at the period value and stays set until software writes 1 to that bit of the flag word. Writing 0 to the bit leaves it set.
- R12: Duty and period writes take effect on the next cycle, even within a period that is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Read data, valid one cycle after bus_rd |
| tick | input | NCH | Per-channel prescaled count enable |
| pwm_out | output | NCH | Per-channel PWM pin |
| period_flag | output | NCH | Per-channel sticky end-of-period flag |

## Verification
A counter that has gone wrong shows up within one period as a wrong count of opposite-level cycles on the pin. A counter that does not stop at the period value runs on to 0xFFFF, and it also leaves the flag unset. A lost or stuck running bit shows at once in the running-status word and within two cycles on the pin. A graceful stop that acts too soon makes the pin fall before the period has run out. The table-driven windows count pin cycles over exactly one period, so any error in the duty or period comparison changes the count. The directed tests read the counter back to confirm that a stop freezes it, or leaves it at 0 after a graceful stop.

// File: rtl/tpwm_pkg.sv
`timescale 1ns/1ps
package tpwm_pkg;
  // control word: bit0 enable, bit1 start level high, bit2 abrupt stop
  typedef struct packed {
    logic abrupt;
    logic init_hi;
    logic pwm_en;
  } tpwm_ctrl_t;

  localparam logic [1:0] OFS_CNT  = 2'd0;
  localparam logic [1:0] OFS_DUTY = 2'd1;
  localparam logic [1:0] OFS_PER  = 2'd2;
  localparam logic [1:0] OFS_CTRL = 2'd3;

  localparam logic [1:0] SH_SET  = 2'd0;
  localparam logic [1:0] SH_CLR  = 2'd1;
  localparam logic [1:0] SH_RUN  = 2'd2;
  localparam logic [1:0] SH_FLAG = 2'd3;
endpackage

// File: rtl/tpwm_chan.sv
`timescale 1ns/1ps
module tpwm_chan
  import tpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_cnt,
  input  logic          wr_duty,
  input  logic          wr_per,
  input  logic          wr_ctrl,
  input  logic [CW-1:0] wdata,
  input  logic          run_set,
  input  logic          run_clr,
  input  logic          flag_clr,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] duty_q,
  output logic [CW-1:0] per_q,
  output tpwm_ctrl_t    ctrl_q,
  output logic          run_q,
  output logic          pin_q,
  output logic          flag_q
);
  logic stop_pend;
  logic at_end;
  logic active;

  assign at_end = run_q && tick && (cnt_q == per_q);
  assign active = (duty_q <= per_q) && (cnt_q >= duty_q) && (cnt_q <= per_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      duty_q    <= '0;
      per_q     <= '0;
      ctrl_q    <= '0;
      run_q     <= 1'b0;
      stop_pend <= 1'b0;
      flag_q    <= 1'b0;
      pin_q     <= 1'b0;
    end else begin
      if (wr_duty) duty_q <= wdata;
      if (wr_per)  per_q  <= wdata;
      if (wr_ctrl) ctrl_q <= tpwm_ctrl_t'(wdata[2:0]);

      if (wr_cnt)
        cnt_q <= wdata;
      else if (run_q && tick)
        cnt_q <= at_end ? '0 : cnt_q + 1'b1;

      if (run_set) begin
        run_q     <= 1'b1;
        stop_pend <= 1'b0;
      end else if (run_clr && run_q) begin
        if (ctrl_q.abrupt) begin
          run_q     <= 1'b0;
          stop_pend <= 1'b0;
        end else begin
          stop_pend <= 1'b1;
        end
      end else if (at_end && stop_pend) begin
        run_q     <= 1'b0;
        stop_pend <= 1'b0;
      end

      if (at_end)        flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;

      pin_q <= (ctrl_q.pwm_en && run_q && active) ? ~ctrl_q.init_hi : ctrl_q.init_hi;
    end
  end

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_cnt && !(run_q && tick)) |=> $stable(cnt_q));
  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick && (cnt_q == per_q) && !wr_cnt) |=> (cnt_q == '0));
  // R5
  duty_over_chk: assert property (@(posedge clk) disable iff (rst)
    (duty_q > per_q) |=> (pin_q == $past(ctrl_q.init_hi)));
  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctrl_q.pwm_en && run_q) |=> (pin_q == $past(ctrl_q.init_hi)));
  // R6
  set_start_chk: assert property (@(posedge clk) disable iff (rst)
    run_set |=> run_q);
  // R9
  abrupt_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (run_clr && !run_set && ctrl_q.abrupt) |=> !run_q);
  // R10
  graceful_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && run_clr && !run_set && !ctrl_q.abrupt && !(tick && (cnt_q == per_q))) |=> run_q);
  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr) |=> flag_q);
endmodule

// File: rtl/tpwm_regif.sv
`timescale 1ns/1ps
module tpwm_regif
  import tpwm_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [AW-1:0]           bus_addr,
  input  logic [CW-1:0]           bus_wdata,
  output logic [CW-1:0]           bus_rdata,
  input  logic [NCH-1:0][CW-1:0]  cnt_all,
  input  logic [NCH-1:0][CW-1:0]  duty_all,
  input  logic [NCH-1:0][CW-1:0]  per_all,
  input  logic [NCH-1:0][2:0]     ctrl_all,
  input  logic [NCH-1:0]          run_all,
  input  logic [NCH-1:0]          flag_all,
  output logic [NCH-1:0]          wr_cnt,
  output logic [NCH-1:0]          wr_duty,
  output logic [NCH-1:0]          wr_per,
  output logic [NCH-1:0]          wr_ctrl,
  output logic [NCH-1:0]          run_set,
  output logic [NCH-1:0]          run_clr,
  output logic [NCH-1:0]          flag_clr
);
  localparam int IW = AW - 2;
  localparam int SW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [IW-1:0] SH_IDX = IW'(NCH);

  logic [IW-1:0] idx;
  logic [1:0]    ofs;
  logic [SW-1:0] sel;
  logic          is_sh;

  assign idx   = bus_addr[AW-1:2];
  assign ofs   = bus_addr[1:0];
  assign sel   = idx[SW-1:0];
  assign is_sh = (idx == SH_IDX);

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    localparam logic [IW-1:0] MY_IDX = IW'(i);
    logic hit;
    assign hit        = bus_wr && (idx == MY_IDX);
    assign wr_cnt[i]  = hit && (ofs == OFS_CNT);
    assign wr_duty[i] = hit && (ofs == OFS_DUTY);
    assign wr_per[i]  = hit && (ofs == OFS_PER);
    assign wr_ctrl[i] = hit && (ofs == OFS_CTRL);
  end

  assign run_set  = (bus_wr && is_sh && ofs == SH_SET)  ? bus_wdata[NCH-1:0] : '0;
  assign run_clr  = (bus_wr && is_sh && ofs == SH_CLR)  ? bus_wdata[NCH-1:0] : '0;
  assign flag_clr = (bus_wr && is_sh && ofs == SH_FLAG) ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (is_sh) begin
        case (ofs)
          SH_RUN:  bus_rdata <= CW'(run_all);
          SH_FLAG: bus_rdata <= CW'(flag_all);
          default: bus_rdata <= '0;
        endcase
      end else if (idx < SH_IDX) begin
        case (ofs)
          OFS_CNT:  bus_rdata <= cnt_all[sel];
          OFS_DUTY: bus_rdata <= duty_all[sel];
          OFS_PER:  bus_rdata <= per_all[sel];
          default:  bus_rdata <= CW'(ctrl_all[sel]);
        endcase
      end
    end
  end
endmodule

// File: rtl/tpwm_bank.sv
`timescale 1ns/1ps
module tpwm_bank
  import tpwm_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int AW  = $clog2(4 * NCH + 4)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [CW-1:0]  bus_wdata,
  output logic [CW-1:0]  bus_rdata,
  input  logic [NCH-1:0] tick,
  output logic [NCH-1:0] pwm_out,
  output logic [NCH-1:0] period_flag
);
  logic [NCH-1:0][CW-1:0] cnt_all;
  logic [NCH-1:0][CW-1:0] duty_all;
  logic [NCH-1:0][CW-1:0] per_all;
  logic [NCH-1:0][2:0]    ctrl_all;
  logic [NCH-1:0]         run_all;
  logic [NCH-1:0]         wr_cnt, wr_duty, wr_per, wr_ctrl;
  logic [NCH-1:0]         run_set, run_clr, flag_clr;

  tpwm_regif #(.NCH(NCH), .CW(CW), .AW(AW)) u_regif (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cnt_all  (cnt_all),
    .duty_all (duty_all),
    .per_all  (per_all),
    .ctrl_all (ctrl_all),
    .run_all  (run_all),
    .flag_all (period_flag),
    .wr_cnt   (wr_cnt),
    .wr_duty  (wr_duty),
    .wr_per   (wr_per),
    .wr_ctrl  (wr_ctrl),
    .run_set  (run_set),
    .run_clr  (run_clr),
    .flag_clr (flag_clr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tpwm_ctrl_t ctrl_i;
    assign ctrl_all[i] = ctrl_i;
    tpwm_chan #(.CW(CW)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick[i]),
      .wr_cnt  (wr_cnt[i]),
      .wr_duty (wr_duty[i]),
      .wr_per  (wr_per[i]),
      .wr_ctrl (wr_ctrl[i]),
      .wdata   (bus_wdata),
      .run_set (run_set[i]),
      .run_clr (run_clr[i]),
      .flag_clr(flag_clr[i]),
      .cnt_q   (cnt_all[i]),
      .duty_q  (duty_all[i]),
      .per_q   (per_all[i]),
      .ctrl_q  (ctrl_i),
      .run_q   (run_all[i]),
      .pin_q   (pwm_out[i]),
      .flag_q  (period_flag[i])
    );
  end
endmodule

// File: tb/sim_tpwm_bank.sv
`timescale 1ns/1ps
module sim_tpwm_bank;
  localparam int NCH = 8;
  localparam int CW  = 16;
  localparam int AW  = 6;
  localparam int SHB = 4 * NCH;

  localparam int NT = 7;
  localparam int T_INIT [NT] = '{0, 1, 0, 0, 0, 1, 0};
  localparam int T_DUTY [NT] = '{3, 3, 0, 5, 7, 12, 1};
  localparam int T_PER  [NT] = '{9, 9, 4, 5, 5, 6, 1};
  localparam int T_EXP  [NT] = '{7, 7, 5, 1, 0, 0, 1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic [NCH-1:0] tick = '0;
  logic [NCH-1:0] pwm_out, period_flag;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tpwm_bank #(.NCH(NCH), .CW(CW), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .pwm_out(pwm_out), .period_flag(period_flag)
  );

  function automatic int ca(int ch, int ofs);
    return 4 * ch + ofs;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = CW'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int v, v2, act, n;
    idle(3);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    rd(ca(0, 0), v);  chk(v == 0, "R1 cnt0", v, 0);
    rd(ca(7, 1), v);  chk(v == 0, "R1 duty7", v, 0);
    rd(ca(4, 3), v);  chk(v == 0, "R1 ctrl4", v, 0);
    rd(SHB + 2, v);   chk(v == 0, "R1 running", v, 0);
    rd(SHB + 3, v);   chk(v == 0, "R1 flags", v, 0);
    chk(pwm_out == 0 && period_flag == 0, "R1 pins", int'(pwm_out), 0);

    // R2 control holds three bits only, duty/period readback
    wr(ca(0, 3), 16'hFFFF); rd(ca(0, 3), v); chk(v == 7, "R2 ctrl width", v, 7);
    wr(ca(0, 3), 0);
    wr(ca(5, 2), 16'hBEEF); rd(ca(5, 2), v); chk(v == 16'hBEEF, "R2 period rb", v, 16'hBEEF);

    // R6 start/stop masks (channels 1 and 3 abrupt)
    wr(ca(1, 3), 4); wr(ca(3, 3), 4);
    wr(SHB + 0, 8'h0A); rd(SHB + 2, v); chk(v == 8'h0A, "R6 set", v, 8'h0A);
    wr(SHB + 0, 0);     rd(SHB + 2, v); chk(v == 8'h0A, "R6 set zero", v, 8'h0A);
    wr(SHB + 1, 8'h02); rd(SHB + 2, v); chk(v == 8'h08, "R6 clear", v, 8'h08);
    wr(SHB + 1, 0);     rd(SHB + 2, v); chk(v == 8'h08, "R6 clear zero", v, 8'h08);

    // R3 counting only on tick while running
    wr(ca(3, 2), 16'hFFFF);
    wr(ca(3, 0), 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); tick = 8'h0A;
      @(negedge clk); tick = 8'h00;
    end
    rd(ca(3, 0), v); chk(v == 5, "R3 five ticks", v, 5);
    rd(ca(1, 0), v); chk(v == 0, "R3 stopped channel", v, 0);
    idle(10);
    rd(ca(3, 0), v); chk(v == 5, "R3 no tick hold", v, 5);

    // R7 counter write
    wr(ca(3, 0), 1234); rd(ca(3, 0), v); chk(v == 1234, "R7 cnt write", v, 1234);
    wr(ca(3, 0), 0);    rd(ca(3, 0), v); chk(v == 0, "R7 cnt zero", v, 0);
    wr(SHB + 1, 8'h08);

    // R4 / R5 table walk on channel 2
    tick = '1;
    for (int i = 0; i < NT; i++) begin
      wr(ca(2, 3), 5 | (T_INIT[i] << 1));
      wr(SHB + 1, 1 << 2);
      wr(ca(2, 1), T_DUTY[i]);
      wr(ca(2, 2), T_PER[i]);
      wr(ca(2, 0), 0);
      wr(SHB + 0, 1 << 2);
      idle(3);
      act = 0;
      for (int k = 0; k <= T_PER[i]; k++) begin
        @(negedge clk);
        if (int'(pwm_out[2]) != T_INIT[i]) act++;
      end
      chk(act == T_EXP[i], (T_DUTY[i] > T_PER[i]) ? "R5 duty over period" : "R4 active span",
          act, T_EXP[i]);
    end

    // R11 sticky flag, write-one clear
    wr(SHB + 1, 1 << 2);
    rd(SHB + 3, v); chk(v == 4, "R11 flag set", v, 4);
    chk(period_flag == 8'h04, "R11 flag port", int'(period_flag), 4);
    wr(SHB + 3, 0);      rd(SHB + 3, v); chk(v == 4, "R11 zero write", v, 4);
    wr(SHB + 3, 1 << 2); rd(SHB + 3, v); chk(v == 0, "R11 cleared", v, 0);

    // R8 disable returns pin to start level
    wr(ca(2, 3), 7); wr(ca(2, 1), 0); wr(ca(2, 2), 10); wr(ca(2, 0), 0);
    wr(SHB + 0, 1 << 2);
    idle(4);
    chk(pwm_out[2] == 1'b0, "R8 active before", int'(pwm_out[2]), 0);
    wr(ca(2, 3), 6);
    idle(1);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pwm_out[2] != 1'b1) n++;
    end
    chk(n == 0, "R8 held at start level", n, 0);

    // R9 abrupt stop
    wr(ca(5, 3), 5); wr(ca(5, 1), 0); wr(ca(5, 2), 100); wr(ca(5, 0), 0);
    wr(SHB + 0, 1 << 5);
    idle(5);
    chk(pwm_out[5] == 1'b1, "R9 active", int'(pwm_out[5]), 1);
    wr(SHB + 1, 1 << 5);
    idle(1);
    chk(pwm_out[5] == 1'b0, "R9 pin dropped", int'(pwm_out[5]), 0);
    rd(ca(5, 0), v); rd(ca(5, 0), v2);
    chk(v == v2, "R9 counter frozen", v2, v);

    // R10 graceful stop
    wr(ca(6, 3), 1); wr(ca(6, 1), 0); wr(ca(6, 2), 40); wr(ca(6, 0), 0);
    wr(SHB + 0, 1 << 6);
    idle(5);
    wr(SHB + 1, 1 << 6);
    chk(pwm_out[6] == 1'b1, "R10 still driving", int'(pwm_out[6]), 1);
    rd(SHB + 2, v); chk(((v >> 6) & 1) == 1, "R10 still running", (v >> 6) & 1, 1);
    n = 0;
    while (pwm_out[6] == 1'b1 && n < 60) begin
      @(negedge clk); n++;
    end
    chk(n > 0 && n < 45, "R10 stops at period end", n, 30);
    rd(SHB + 2, v);  chk(((v >> 6) & 1) == 0, "R10 halted", (v >> 6) & 1, 0);
    rd(ca(6, 0), v); chk(v == 0, "R10 counter zero", v, 0);

    // R12 duty takes effect without shadowing
    wr(ca(7, 3), 5); wr(ca(7, 1), 0); wr(ca(7, 2), 1000); wr(ca(7, 0), 0);
    wr(SHB + 0, 1 << 7);
    idle(5);
    chk(pwm_out[7] == 1'b1, "R12 active", int'(pwm_out[7]), 1);
    wr(ca(7, 1), 16'hFFFF);
    idle(1);
    chk(pwm_out[7] == 1'b0, "R12 duty raised", int'(pwm_out[7]), 0);
    wr(ca(7, 1), 0);
    idle(1);
    chk(pwm_out[7] == 1'b1, "R12 duty lowered", int'(pwm_out[7]), 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule